// File: doc/BRIEF.md
# Translation Lookaside Buffer with Explicit Invalidation

This block is a small, fully associative cache that holds recent virtual-to-physical translations in front of a page table walker. A lookup presents a 36-bit virtual page number and the kind of access: write, user mode or instruction fetch. In the same cycle the block answers with one of three results. A hit returns the 4 KiB frame number, the page size and the stored rights. A protection fault means a matching entry exists but does not allow the access. A walk request means no entry covers the page, and the walker receives the page number.

The walker returns its result through a fill port. An entry holds a 4 KiB, 2 MiB or 1 GiB mapping, together with the effective rights and a global flag. Entries are never refreshed on their own when page tables change in memory. Two commands remove them. The first drops the entry that covers a given page. The second is a root-register reload, which clears every entry that is not global, as happens on an address-space switch.

Top module: `tlb_cache`

## Requirements
- R1: After reset no entry is valid, so every lookup requests a walk and none hits.
- R2: A lookup that no valid entry covers asserts `walk_req` in the same cycle, with `walk_vpn` equal to `lk_vpn`, and asserts neither `lk_hit` nor `lk_fault`.
- R3: A lookup covered by a 4 KiB entry (size code 0) that allows the access asserts `lk_hit` in the same cycle and returns the stored frame, size and rights.
- R4: A 2 MiB entry (size code 1) compares only page bits 35..9, and a 1 GiB entry (size code 2) compares only bits 35..18. On a hit, the low 9 or 18 bits of `lk_pfn` come from `lk_vpn` and the rest come from the stored frame.
- R5: A covered lookup that writes to a non-writable page, accesses a supervisor page in user mode, or fetches from a no-execute page asserts `lk_fault` instead of `lk_hit`, and does not request a walk.
- R6: `inv_valid` with a page number removes the entry that covers that page, from any address inside a large page, so the next lookup of that page misses. Other entries are kept.
- R7: `root_reload` removes every non-global entry and keeps the entries filled with `fill_glob` set.
- R8: A single-page invalidate also removes a global entry.
- R9: A fill is discarded when, in the same cycle, `inv_valid` names a page that the fill would cover, or when `root_reload` is asserted and the fill is not global.
- R10: A fill goes to the lowest free slot. When all slots are valid, it replaces slots in round-robin order starting at slot 0. The pointer advances only on such replacements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup present |
| lk_vpn | input | 36 | Lookup virtual page number |
| lk_write | input | 1 | Access is a write |
| lk_user | input | 1 | Access is from user mode |
| lk_exec | input | 1 | Access is an instruction fetch |
| lk_hit | output | 1 | Translation found and allowed |
| lk_fault | output | 1 | Translation found but access not allowed |
| lk_pfn | output | 40 | Translated 4 KiB frame number |
| lk_size | output | 2 | Size code of matching entry (0 4K, 1 2M, 2 1G) |
| lk_wr | output | 1 | Matching entry is writable |
| lk_us | output | 1 | Matching entry is user accessible |
| lk_nx | output | 1 | Matching entry forbids execution |
| walk_req | output | 1 | Miss: walk requested |
| walk_vpn | output | 36 | Page number to walk |
| fill_valid | input | 1 | Walker result present |
| fill_vpn | input | 36 | Page number of the result |
| fill_pfn | input | 40 | Frame number of the result (aligned to its size) |
| fill_size | input | 2 | Size code of the result |
| fill_wr | input | 1 | Effective writable right |
| fill_us | input | 1 | Effective user right |
| fill_nx | input | 1 | Effective no-execute flag |
| fill_glob | input | 1 | Entry survives a root reload |
| inv_valid | input | 1 | Single-page invalidate |
| inv_vpn | input | 36 | Page to invalidate |
| root_reload | input | 1 | Root register reloaded: flush non-global entries |

## Verification
Lookups are run against a set of resident mappings of all three sizes. The probes land inside each mapping, one page past its boundary, and at its extreme offsets. Together they show whether the compare mask and the frame merge follow the entry's size. Each of the three permission bits is then tried against each kind of access, which separates a fault from a hit and from a miss. Directed sequences then remove entries with both commands and issue commands in the same cycle as a fill. They also fill the buffer past capacity with a slot freed in between, which shows whether free-first placement is followed and whether the round-robin pointer is left untouched by it.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VPN_W    = 36;
    localparam int PFN_W    = 40;
    localparam int LVL_BITS = 9;

    typedef enum logic [1:0] {
        PG_4K = 2'd0,
        PG_2M = 2'd1,
        PG_1G = 2'd2
    } pg_size_e;

    typedef struct packed {
        logic wr;
        logic us;
        logic nx;
    } perm_t;

    typedef struct packed {
        logic              vld;
        logic              glob;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
        pg_size_e          size;
        perm_t             perm;
    } tlb_ent_t;

    // Mask of the page-number bits that take part in the compare.
    function automatic logic [VPN_W-1:0] size_mask(pg_size_e s);
        logic [VPN_W-1:0] m;
        m = '1;
        case (s)
            PG_2M:   m[LVL_BITS-1:0]   = '0;
            PG_1G:   m[2*LVL_BITS-1:0] = '0;
            default: m = '1;
        endcase
        return m;
    endfunction

    function automatic logic covers(tlb_ent_t e, logic [VPN_W-1:0] vpn);
        return e.vld && (((e.vpn ^ vpn) & size_mask(e.size)) == '0);
    endfunction

    // Merge the in-page part of the virtual number into the frame.
    function automatic logic [PFN_W-1:0] merge_pfn(tlb_ent_t e, logic [VPN_W-1:0] vpn);
        logic [PFN_W-1:0] m;
        m = {{(PFN_W-VPN_W){1'b1}}, size_mask(e.size)};
        return (e.pfn & m) | ({{(PFN_W-VPN_W){1'b0}}, vpn} & ~m);
    endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int N = 16
) (
    input  tlb_ent_t          ents [N],
    input  logic [VPN_W-1:0]  vpn,
    output logic [N-1:0]      hit_vec
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit_vec[i] = covers(ents[i], vpn);
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N     = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     vld_vec,
    input  logic             take,
    output logic [IDX_W-1:0] slot
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             free_found;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld_vec[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
        slot = free_found ? free_idx : rr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (take && !free_found) begin
            rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/tlb_cache.sv
module tlb_cache
    import tlb_pkg::*;
#(
    parameter int N = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic              lk_write,
    input  logic              lk_user,
    input  logic              lk_exec,
    output logic              lk_hit,
    output logic              lk_fault,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic [1:0]        lk_size,
    output logic              lk_wr,
    output logic              lk_us,
    output logic              lk_nx,
    output logic              walk_req,
    output logic [VPN_W-1:0]  walk_vpn,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [1:0]        fill_size,
    input  logic              fill_wr,
    input  logic              fill_us,
    input  logic              fill_nx,
    input  logic              fill_glob,
    input  logic              inv_valid,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic              root_reload
);
    localparam int IDX_W = $clog2(N);

    tlb_ent_t         ents [N];
    tlb_ent_t         new_ent;
    tlb_ent_t         sel;
    logic [N-1:0]     lk_match;
    logic [N-1:0]     inv_match;
    logic [N-1:0]     vld_vec;
    logic [N-1:0]     glob_vec;
    logic [IDX_W-1:0] slot;
    logic             fill_go;
    logic             any_match;
    logic             violation;

    for (genvar i = 0; i < N; i++) begin : g_flags
        assign vld_vec[i]  = ents[i].vld;
        assign glob_vec[i] = ents[i].glob;
    end

    tlb_match #(.N(N)) u_lk_match (
        .ents    (ents),
        .vpn     (lk_vpn),
        .hit_vec (lk_match)
    );

    tlb_match #(.N(N)) u_inv_match (
        .ents    (ents),
        .vpn     (inv_vpn),
        .hit_vec (inv_match)
    );

    always_comb begin
        new_ent      = '0;
        new_ent.vld  = 1'b1;
        new_ent.glob = fill_glob;
        new_ent.vpn  = fill_vpn;
        new_ent.pfn  = fill_pfn;
        new_ent.size = pg_size_e'(fill_size);
        new_ent.perm = '{wr: fill_wr, us: fill_us, nx: fill_nx};
        // A same-cycle invalidate or non-global flush wins over the fill.
        fill_go = fill_valid
                  && !(inv_valid && covers(new_ent, inv_vpn))
                  && !(root_reload && !fill_glob);
    end

    tlb_victim #(.N(N)) u_victim (
        .clk     (clk),
        .rst     (rst),
        .vld_vec (vld_vec),
        .take    (fill_go),
        .slot    (slot)
    );

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst) begin
                ents[i] <= '0;
            end else if (fill_go && slot == IDX_W'(i)) begin
                ents[i] <= new_ent;
            end else if ((inv_valid && inv_match[i]) ||
                         (root_reload && !ents[i].glob)) begin
                ents[i].vld <= 1'b0;
            end
        end
    end

    // Lowest matching slot drives the result.
    always_comb begin
        sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (lk_match[i]) sel = ents[i];
        end
        any_match = |lk_match;
        violation = (lk_write && !sel.perm.wr) ||
                    (lk_user  && !sel.perm.us) ||
                    (lk_exec  &&  sel.perm.nx);
    end

    assign lk_hit   = lk_valid && any_match && !violation;
    assign lk_fault = lk_valid && any_match &&  violation;
    assign walk_req = lk_valid && !any_match;
    assign walk_vpn = lk_vpn;
    assign lk_pfn   = any_match ? merge_pfn(sel, lk_vpn) : '0;
    assign lk_size  = sel.size;
    assign lk_wr    = sel.perm.wr;
    assign lk_us    = sel.perm.us;
    assign lk_nx    = sel.perm.nx;

endmodule

// File: rtl/tlb_cache_chk.sv
module tlb_cache_chk
    import tlb_pkg::*;
#(
    parameter int N = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_valid,
    input logic [VPN_W-1:0] lk_vpn,
    input logic             lk_write,
    input logic             lk_hit,
    input logic             lk_fault,
    input logic             lk_wr,
    input logic             walk_req,
    input logic             inv_valid,
    input logic [VPN_W-1:0] inv_vpn,
    input logic             root_reload,
    input logic [N-1:0]     vld_vec,
    input logic [N-1:0]     glob_vec
);
    assert_reset_empty_R1: assert property (@(posedge clk)
        rst |=> (vld_vec == '0));

    assert_walk_only_on_lookup_R2: assert property (@(posedge clk) disable iff (rst)
        walk_req |-> lk_valid);

    assert_one_outcome_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lk_hit, lk_fault, walk_req}));

    assert_write_needs_right_R5: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && lk_write) |-> lk_wr);

    assert_inval_removes_R6: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && $past(inv_valid) && lk_vpn == $past(inv_vpn)) |-> (!lk_hit && !lk_fault));

    assert_reload_keeps_global_R7: assert property (@(posedge clk) disable iff (rst)
        root_reload |=> ((vld_vec & ~glob_vec) == '0));
endmodule

bind tlb_cache tlb_cache_chk #(.N(N)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .lk_valid    (lk_valid),
    .lk_vpn      (lk_vpn),
    .lk_write    (lk_write),
    .lk_hit      (lk_hit),
    .lk_fault    (lk_fault),
    .lk_wr       (lk_wr),
    .walk_req    (walk_req),
    .inv_valid   (inv_valid),
    .inv_vpn     (inv_vpn),
    .root_reload (root_reload),
    .vld_vec     (vld_vec),
    .glob_vec    (glob_vec)
);

// File: tb/tb_tlb_cache.sv
module tb_tlb_cache;
    localparam int CLK_P = 10;
    localparam int NV    = 12;

    logic        clk = 1'b0;
    logic        rst;
    logic        lk_valid, lk_write, lk_user, lk_exec;
    logic [35:0] lk_vpn;
    logic        lk_hit, lk_fault, lk_wr, lk_us, lk_nx, walk_req;
    logic [39:0] lk_pfn;
    logic [1:0]  lk_size;
    logic [35:0] walk_vpn;
    logic        fill_valid, fill_wr, fill_us, fill_nx, fill_glob;
    logic [35:0] fill_vpn;
    logic [39:0] fill_pfn;
    logic [1:0]  fill_size;
    logic        inv_valid, root_reload;
    logic [35:0] inv_vpn;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_P/2) clk = ~clk;

    tlb_cache dut (.*);

    // {vpn, {write,user,exec}, outcome 0 miss/1 hit/2 fault, expected pfn}
    localparam logic [80:0] VEC [NV] = '{
        {36'h000000123, 3'b000, 2'd1, 40'h00000000AB},
        {36'h000000123, 3'b110, 2'd1, 40'h00000000AB},
        {36'h000000124, 3'b000, 2'd0, 40'h0},
        {36'h0004003FF, 3'b010, 2'd1, 40'h00000011FF},
        {36'h000400205, 3'b100, 2'd2, 40'h0000001005},
        {36'h000400200, 3'b001, 2'd2, 40'h0000001000},
        {36'h000400400, 3'b000, 2'd0, 40'h0},
        {36'h0000FFFFF, 3'b000, 2'd1, 40'h000007FFFF},
        {36'h0000C0012, 3'b010, 2'd2, 40'h0000040012},
        {36'h000100000, 3'b000, 2'd0, 40'h0},
        {36'h000000123, 3'b001, 2'd1, 40'h00000000AB},
        {36'h000000000, 3'b000, 2'd0, 40'h0}
    };

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic look(logic [35:0] v, logic [2:0] acc);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vpn   = v;
        {lk_write, lk_user, lk_exec} = acc;
        #2;
    endtask

    // outcome: 0 miss, 1 hit, 2 fault
    task automatic expect_outcome(string req, logic [35:0] v, logic [1:0] oc);
        look(v, 3'b000);
        check(req, {61'd0, lk_hit, lk_fault, walk_req},
              {61'd0, oc == 2'd1, oc == 2'd2, oc == 2'd0});
    endtask

    task automatic fill(logic [35:0] v, logic [39:0] p, logic [1:0] sz,
                        logic [2:0] perm, logic g, logic with_inv, logic with_reload);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = v; fill_pfn = p; fill_size = sz;
        {fill_wr, fill_us, fill_nx} = perm; fill_glob = g;
        inv_valid = with_inv; inv_vpn = v; root_reload = with_reload;
        @(posedge clk); #1;
        fill_valid = 1'b0; inv_valid = 1'b0; root_reload = 1'b0;
    endtask

    task automatic inval(logic [35:0] v);
        @(negedge clk);
        inv_valid = 1'b1; inv_vpn = v;
        @(posedge clk); #1;
        inv_valid = 1'b0;
    endtask

    task automatic reload();
        @(negedge clk);
        root_reload = 1'b1;
        @(posedge clk); #1;
        root_reload = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; lk_valid = 0; lk_vpn = '0; lk_write = 0; lk_user = 0; lk_exec = 0;
        fill_valid = 0; fill_vpn = '0; fill_pfn = '0; fill_size = '0;
        fill_wr = 0; fill_us = 0; fill_nx = 0; fill_glob = 0;
        inv_valid = 0; inv_vpn = '0; root_reload = 0;
        do_reset();

        // R1: empty after reset
        look(36'h000000123, 3'b000);
        check("R1", {62'd0, walk_req, lk_hit}, {62'd0, 1'b1, 1'b0});

        // Mappings: 4K A, 2M B (read/user/nx), 1G C (write/supervisor, global)
        fill(36'h000000123, 40'h00000000AB, 2'd0, 3'b110, 1'b0, 1'b0, 1'b0);
        fill(36'h000400200, 40'h0000001000, 2'd1, 3'b011, 1'b0, 1'b0, 1'b0);
        fill(36'h0000C0000, 40'h0000040000, 2'd2, 3'b100, 1'b1, 1'b0, 1'b0);

        for (int k = 0; k < NV; k++) begin
            logic [35:0] v;
            logic [1:0]  oc;
            logic [39:0] ep;
            string       tag;
            {v, oc, ep} = {VEC[k][80:45], VEC[k][41:40], VEC[k][39:0]};
            tag = (oc == 2'd0) ? "R2" : (oc == 2'd1) ? "R3/R4" : "R5";
            look(v, VEC[k][44:42]);
            check(tag, {61'd0, lk_hit, lk_fault, walk_req},
                  {61'd0, oc == 2'd1, oc == 2'd2, oc == 2'd0});
            if (oc != 2'd0) check(tag, {24'd0, lk_pfn}, {24'd0, ep});
            else            check("R2", {28'd0, walk_vpn}, {28'd0, v});
        end

        // R3: size and rights of the 4K entry; R4: size code of the 2M entry
        look(36'h000000123, 3'b000);
        check("R3", {59'd0, lk_size, lk_wr, lk_us, lk_nx}, {59'd0, 2'd0, 3'b110});
        look(36'h000400210, 3'b000);
        check("R4", {62'd0, lk_size}, {62'd0, 2'd1});

        // R6: invalidate inside the 2M page removes it, A stays
        inval(36'h000400333);
        expect_outcome("R6", 36'h000400201, 2'd0);
        expect_outcome("R6", 36'h000000123, 2'd1);

        // R7: reload drops A, keeps global C
        reload();
        expect_outcome("R7", 36'h000000123, 2'd0);
        expect_outcome("R7", 36'h0000C0001, 2'd1);

        // R8: single-page invalidate drops global C
        inval(36'h0000C0005);
        expect_outcome("R8", 36'h0000C0001, 2'd0);

        // R9: fill collides with invalidate or with reload
        fill(36'h000000555, 40'h77, 2'd0, 3'b110, 1'b0, 1'b1, 1'b0);
        expect_outcome("R9", 36'h000000555, 2'd0);
        fill(36'h000000666, 40'h78, 2'd0, 3'b110, 1'b0, 1'b0, 1'b1);
        expect_outcome("R9", 36'h000000666, 2'd0);
        fill(36'h000000777, 40'h79, 2'd0, 3'b110, 1'b1, 1'b0, 1'b1);
        expect_outcome("R9", 36'h000000777, 2'd1);

        // R10: free-first then round robin from slot 0
        do_reset();
        for (int i = 0; i < 16; i++)
            fill(36'h000001000 + 36'(i), 40'(i), 2'd0, 3'b110, 1'b0, 1'b0, 1'b0);
        fill(36'h000002000, 40'h200, 2'd0, 3'b110, 1'b0, 1'b0, 1'b0);
        expect_outcome("R10", 36'h000001000, 2'd0);
        expect_outcome("R10", 36'h000001001, 2'd1);
        expect_outcome("R10", 36'h000002000, 2'd1);
        fill(36'h000002001, 40'h201, 2'd0, 3'b110, 1'b0, 1'b0, 1'b0);
        expect_outcome("R10", 36'h000001001, 2'd0);
        inval(36'h000001005);
        fill(36'h000003000, 40'h300, 2'd0, 3'b110, 1'b0, 1'b0, 1'b0);
        expect_outcome("R10", 36'h000001002, 2'd1);
        expect_outcome("R10", 36'h000003000, 2'd1);
        fill(36'h000003001, 40'h301, 2'd0, 3'b110, 1'b0, 1'b0, 1'b0);
        expect_outcome("R10", 36'h000001002, 2'd0);
        expect_outcome("R10", 36'h000001003, 2'd1);
        look(36'h000003000, 3'b000);
        check("R10", {24'd0, lk_pfn}, {24'd0, 40'h300});

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule